// File: doc/BRIEF.md
# Descriptor Command Dispatcher

This block sits between a DMA channel's descriptor fetch stage and its transfer engine. When the channel is running and active and a freshly fetched descriptor is presented, it reads the 16-bit command halfword and issues exactly one action. The action is one of these: start a data transfer toward the device or from it, flagged as a middle or a final piece; read a word into the descriptor's dependent field; write a word out of that field; do nothing; halt; or kill the channel because the parameters are illegal.

For word reads and writes, the block reduces the request count to a 1, 2 or 4 byte size and forces the address onto that size's boundary. For stores it extracts the high-order bytes of the dependent field. For loads it merges the returned bytes into the top of that field and keeps the remaining low bits. Data and word operations hold a busy flag until the transfer engine reports completion. The completion pulse then carries whether the finishing command may take its branch. The bus engine, the status register and the branch, interrupt and wait condition logic lie outside the block and act on its strobes.

Top module: `desc_cmd_dispatch`

## Requirements
- R1: An action is accepted only on a clock edge where `fetch_valid`, `run` and `active` are all 1 and `busy` is 0. Every accepted fetch pulses `wake_clr` for one cycle. All action strobes and qualifiers appear in the cycle after the accepting edge and last exactly one cycle.
- R2: The opcode is command bits 15:12. The codes are 0 output-more, 1 output-last, 2 input-more, 3 input-last, 4 store-word, 5 load-word, 6 no-op and 7 stop. These drive `out_go`, `in_go`, `st_go`, `ld_go`, `nop_go` and `stop_go`. `xfer_last` is 1 only for codes 1 and 3. A data transfer passes `req_cnt` and `data_addr` through unchanged. Bits 11 and 7:0 are latched to `ctl_bits` as {bit11, bits7:0}.
- R3: The key is command bits 10:8. A data transfer (codes 0 to 3) kills the channel instead of starting if the key is 4 or more, or if the address is zero.
- R4: For codes 4 and 5, only `req_cnt[2:0]` is used. If bit 2 is set, the size is 4 bytes and address bits 1:0 are cleared. Otherwise, if bit 1 is set, the size is 2 bytes and address bit 0 is cleared. Otherwise the size is 1 byte and the address is unchanged. The size appears on `xfer_len`.
- R5: For codes 4 and 5, keys 0 to 3 are treated as the system key (6). Key 4, key 5 and key 7 kill the channel.
- R6: A load completion writes the dependent field through `dep_we`/`dep_out`. A 4-byte load writes `load_data`. A 2-byte load writes {load_data[15:0], dep[15:0]}. A 1-byte load writes {load_data[7:0], dep[23:0]}. Here dep is the `dep_in` value captured at dispatch.
- R7: A store drives `store_data` with `dep_in` as is for 4 bytes, shifted right by 16 for 2 bytes, or shifted right by 24 for 1 byte.
- R8: Data and word actions set `busy`. The first `xfer_done` while busy clears it and pulses `cmpl` for one cycle. `cmpl_may_branch` is 1 after data transfers and 0 after word loads and stores.
- R9: Kill, stop, no-op and undefined opcodes (8 to 15) leave `busy` at 0. An undefined opcode raises no action strobe.
- R10: After reset, all strobes, `busy`, `cmpl`, `dep_we` and the data outputs are 0.
- R11: At most one of the seven action strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Channel run status bit |
| active | input | 1 | Channel active status bit |
| fetch_valid | input | 1 | A fetched descriptor is presented |
| cmd_word | input | 16 | Command halfword of the descriptor |
| req_cnt | input | CNT_W | Request count field |
| data_addr | input | ADDR_W | Data address field |
| dep_in | input | 32 | Dependent field of the descriptor |
| xfer_done | input | 1 | Transfer engine finished the pending operation |
| load_data | input | 32 | Bytes returned by a word load, right-aligned |
| out_go | output | 1 | Start a transfer toward the device |
| in_go | output | 1 | Start a transfer from the device |
| ld_go | output | 1 | Start a word load |
| st_go | output | 1 | Start a word store |
| nop_go | output | 1 | No-op: completion path only |
| stop_go | output | 1 | Clear active, dead and flush; keep the command pointer |
| kill | output | 1 | Set dead, clear active, raise the interrupt |
| xfer_last | output | 1 | Transfer is the final piece |
| xfer_addr | output | ADDR_W | Transfer address (aligned for word ops) |
| xfer_len | output | CNT_W | Transfer length in bytes |
| store_data | output | 32 | Right-aligned data for a word store |
| ctl_bits | output | 9 | Command bit 11 and bits 7:0, held for the completion stage |
| wake_clr | output | 1 | Clear the wake status bit |
| busy | output | 1 | An operation is pending in the engine |
| cmpl | output | 1 | Pending operation finished |
| cmpl_may_branch | output | 1 | Finishing command may branch |
| dep_out | output | 32 | New dependent field after a load |
| dep_we | output | 1 | Write strobe for `dep_out` |

## Verification
On every cycle, the embedded properties check the following. The action strobes are mutually exclusive. No action issues while busy. Word accesses carry only legal sizes on aligned addresses. A kill never coexists with busy. The dependent-field write and the completion pulse follow only a busy period and last a single cycle. Only the bench's scenarios can show that each opcode and key maps to the right action, which addresses and keys kill, the priority order of the size code bits, and the exact byte merge and extract values. The same holds for gating by run, active and busy.

// File: rtl/cmdisp_pkg.sv
package cmdisp_pkg;

    localparam int CMD_W = 16;
    localparam int DEP_W = 32;

    typedef enum logic [3:0] {
        OP_OUT_MORE = 4'd0,
        OP_OUT_LAST = 4'd1,
        OP_IN_MORE  = 4'd2,
        OP_IN_LAST  = 4'd3,
        OP_STORE_WD = 4'd4,
        OP_LOAD_WD  = 4'd5,
        OP_NOP      = 4'd6,
        OP_STOP     = 4'd7
    } op_e;

    localparam logic [2:0] KEY_STREAM_TOP = 3'd3;
    localparam logic [2:0] KEY_FORBIDDEN  = 3'd4;
    localparam logic [2:0] KEY_REG_BASE   = 3'd5;
    localparam logic [2:0] KEY_SYS        = 3'd6;

    typedef struct packed {
        logic kill;
        logic stop_go;
        logic nop_go;
        logic st_go;
        logic ld_go;
        logic in_go;
        logic out_go;
    } act_t;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2
    } wsz_e;

    // highest set bit of the 3-bit code wins
    function automatic wsz_e norm_size(input logic [2:0] code);
        if (code[2])      return SZ_4;
        else if (code[1]) return SZ_2;
        else              return SZ_1;
    endfunction

    function automatic logic [DEP_W-1:0] store_lane(input logic [DEP_W-1:0] dep,
                                                     input wsz_e sz);
        case (sz)
            SZ_4:    return dep;
            SZ_2:    return {16'h0000, dep[31:16]};
            default: return {24'h000000, dep[31:24]};
        endcase
    endfunction

    function automatic logic [DEP_W-1:0] merge_lane(input logic [DEP_W-1:0] dep,
                                                     input logic [DEP_W-1:0] rd,
                                                     input wsz_e sz);
        case (sz)
            SZ_4:    return rd;
            SZ_2:    return {rd[15:0], dep[15:0]};
            default: return {rd[7:0], dep[23:0]};
        endcase
    endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import cmdisp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] addr,
    output act_t              act,
    output logic [ADDR_W-1:0] xaddr,
    output logic [CNT_W-1:0]  xlen,
    output logic              last,
    output logic              is_word,
    output wsz_e              wsz
);
    op_e        op;
    logic [2:0] key;
    logic [2:0] eff_key;
    logic       data_bad;
    logic       word_bad;

    assign op      = op_e'(cmd[15:12]);
    assign key     = cmd[10:8];
    assign wsz     = norm_size(cnt[2:0]);
    // stream keys fold onto the system key for word commands
    assign eff_key = (key < KEY_REG_BASE) ? KEY_SYS : key;

    assign data_bad = (key == KEY_FORBIDDEN) || (key > KEY_STREAM_TOP) ||
                      (addr == '0);
    assign word_bad = (key == KEY_FORBIDDEN) || (eff_key != KEY_SYS);

    always_comb begin
        act     = '0;
        xaddr   = addr;
        xlen    = cnt;
        last    = 1'b0;
        is_word = 1'b0;
        case (op)
            OP_OUT_MORE, OP_OUT_LAST: begin
                if (data_bad) act.kill   = 1'b1;
                else          act.out_go = 1'b1;
                last = (op == OP_OUT_LAST);
            end
            OP_IN_MORE, OP_IN_LAST: begin
                if (data_bad) act.kill  = 1'b1;
                else          act.in_go = 1'b1;
                last = (op == OP_IN_LAST);
            end
            OP_LOAD_WD, OP_STORE_WD: begin
                is_word = 1'b1;
                case (wsz)
                    SZ_4: begin
                        xaddr = {addr[ADDR_W-1:2], 2'b00};
                        xlen  = CNT_W'(4);
                    end
                    SZ_2: begin
                        xaddr = {addr[ADDR_W-1:1], 1'b0};
                        xlen  = CNT_W'(2);
                    end
                    default: xlen = CNT_W'(1);
                endcase
                if (word_bad)               act.kill  = 1'b1;
                else if (op == OP_LOAD_WD)  act.ld_go = 1'b1;
                else                        act.st_go = 1'b1;
            end
            OP_NOP:  act.nop_go  = 1'b1;
            OP_STOP: act.stop_go = 1'b1;
            default: act = '0;
        endcase
    end

endmodule

// File: rtl/word_lane.sv
module word_lane
    import cmdisp_pkg::*;
(
    input  logic [DEP_W-1:0] st_dep,
    input  wsz_e             st_sz,
    input  logic [DEP_W-1:0] ld_dep,
    input  logic [DEP_W-1:0] ld_rd,
    input  wsz_e             ld_sz,
    output logic [DEP_W-1:0] st_val,
    output logic [DEP_W-1:0] ld_val
);
    assign st_val = store_lane(st_dep, st_sz);
    assign ld_val = merge_lane(ld_dep, ld_rd, ld_sz);
endmodule

// File: rtl/desc_cmd_dispatch.sv
module desc_cmd_dispatch
    import cmdisp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              active,
    input  logic              fetch_valid,
    input  logic [15:0]       cmd_word,
    input  logic [CNT_W-1:0]  req_cnt,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [31:0]       dep_in,
    input  logic              xfer_done,
    input  logic [31:0]       load_data,
    output logic              out_go,
    output logic              in_go,
    output logic              ld_go,
    output logic              st_go,
    output logic              nop_go,
    output logic              stop_go,
    output logic              kill,
    output logic              xfer_last,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [CNT_W-1:0]  xfer_len,
    output logic [31:0]       store_data,
    output logic [8:0]        ctl_bits,
    output logic              wake_clr,
    output logic              busy,
    output logic              cmpl,
    output logic              cmpl_may_branch,
    output logic [31:0]       dep_out,
    output logic              dep_we
);
    act_t              dec_act;
    logic [ADDR_W-1:0] dec_addr;
    logic [CNT_W-1:0]  dec_len;
    logic              dec_last;
    logic              dec_word;
    wsz_e              dec_sz;

    act_t              act_q;
    logic              busy_q;
    logic              pend_load;
    logic              pend_word;
    wsz_e              sz_q;
    logic [DEP_W-1:0]  dep_q;
    logic [DEP_W-1:0]  st_val;
    logic [DEP_W-1:0]  ld_val;
    logic              accept;
    logic              engine_op;

    cmd_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
        .cmd     (cmd_word),
        .cnt     (req_cnt),
        .addr    (data_addr),
        .act     (dec_act),
        .xaddr   (dec_addr),
        .xlen    (dec_len),
        .last    (dec_last),
        .is_word (dec_word),
        .wsz     (dec_sz)
    );

    word_lane u_lane (
        .st_dep (dep_in),
        .st_sz  (dec_sz),
        .ld_dep (dep_q),
        .ld_rd  (load_data),
        .ld_sz  (sz_q),
        .st_val (st_val),
        .ld_val (ld_val)
    );

    assign accept    = fetch_valid && run && active && !busy_q;
    assign engine_op = dec_act.out_go || dec_act.in_go ||
                       dec_act.ld_go  || dec_act.st_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q           <= '0;
            busy_q          <= 1'b0;
            pend_load       <= 1'b0;
            pend_word       <= 1'b0;
            sz_q            <= SZ_1;
            dep_q           <= '0;
            xfer_last       <= 1'b0;
            xfer_addr       <= '0;
            xfer_len        <= '0;
            store_data      <= '0;
            ctl_bits        <= '0;
            wake_clr        <= 1'b0;
            cmpl            <= 1'b0;
            cmpl_may_branch <= 1'b0;
            dep_out         <= '0;
            dep_we          <= 1'b0;
        end else begin
            act_q    <= '0;
            wake_clr <= 1'b0;
            cmpl     <= 1'b0;
            dep_we   <= 1'b0;
            if (accept) begin
                act_q      <= dec_act;
                wake_clr   <= 1'b1;
                xfer_last  <= dec_last;
                xfer_addr  <= dec_addr;
                xfer_len   <= dec_len;
                store_data <= st_val;
                ctl_bits   <= {cmd_word[11], cmd_word[7:0]};
                if (engine_op) begin
                    busy_q    <= 1'b1;
                    pend_load <= dec_act.ld_go;
                    pend_word <= dec_word;
                    sz_q      <= dec_sz;
                    dep_q     <= dep_in;
                end
            end else if (busy_q && xfer_done) begin
                busy_q          <= 1'b0;
                cmpl            <= 1'b1;
                cmpl_may_branch <= !pend_word;
                if (pend_load) begin
                    dep_out <= ld_val;
                    dep_we  <= 1'b1;
                end
            end
        end
    end

    assign out_go  = act_q.out_go;
    assign in_go   = act_q.in_go;
    assign ld_go   = act_q.ld_go;
    assign st_go   = act_q.st_go;
    assign nop_go  = act_q.nop_go;
    assign stop_go = act_q.stop_go;
    assign kill    = act_q.kill;
    assign busy    = busy_q;

    AST_ONEHOT_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({kill, stop_go, nop_go, st_go, ld_go, in_go, out_go})); // R11

    AST_NO_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> !(out_go || in_go || ld_go || st_go || nop_go || stop_go || kill)); // R1

    AST_WORD_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (ld_go || st_go) |-> (xfer_len == CNT_W'(1) || xfer_len == CNT_W'(2) ||
                              xfer_len == CNT_W'(4))); // R4

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (ld_go || st_go) |-> ((xfer_len != CNT_W'(4) || xfer_addr[1:0] == 2'b00) &&
                              (xfer_len != CNT_W'(2) || xfer_addr[0] == 1'b0))); // R4

    AST_KILL_IDLE: assert property (@(posedge clk) disable iff (rst)
        kill |-> !busy); // R9

    AST_DEP_WRITE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        dep_we |-> ($past(busy) && cmpl)); // R6

    AST_CMPL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmpl |=> !cmpl); // R8

endmodule

// File: tb/tb_desc_cmd_dispatch.sv
module tb_desc_cmd_dispatch;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          run, active, fetch_valid, xfer_done;
    logic [15:0]   cmd_word;
    logic [CW-1:0] req_cnt;
    logic [AW-1:0] data_addr;
    logic [31:0]   dep_in, load_data;
    logic          out_go, in_go, ld_go, st_go, nop_go, stop_go, kill, xfer_last;
    logic [AW-1:0] xfer_addr;
    logic [CW-1:0] xfer_len;
    logic [31:0]   store_data, dep_out;
    logic [8:0]    ctl_bits;
    logic          wake_clr, busy, cmpl, cmpl_may_branch, dep_we;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    desc_cmd_dispatch #(.ADDR_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .run(run), .active(active), .fetch_valid(fetch_valid),
        .cmd_word(cmd_word), .req_cnt(req_cnt), .data_addr(data_addr), .dep_in(dep_in),
        .xfer_done(xfer_done), .load_data(load_data), .out_go(out_go), .in_go(in_go),
        .ld_go(ld_go), .st_go(st_go), .nop_go(nop_go), .stop_go(stop_go), .kill(kill),
        .xfer_last(xfer_last), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .store_data(store_data), .ctl_bits(ctl_bits), .wake_clr(wake_clr), .busy(busy),
        .cmpl(cmpl), .cmpl_may_branch(cmpl_may_branch), .dep_out(dep_out), .dep_we(dep_we)
    );

    // {cmd, cnt, addr, expected strobes {kill,stop,nop,st,ld,in,out}, exp addr, exp len}
    localparam logic [119:0] VEC [NV] = '{
        {16'h0000, 16'h0100, 32'h0000_8000, 8'h01, 32'h0000_8000, 16'h0100},
        {16'h1300, 16'h0040, 32'h0000_9004, 8'h01, 32'h0000_9004, 16'h0040},
        {16'h2200, 16'h0010, 32'h0000_A001, 8'h02, 32'h0000_A001, 16'h0010},
        {16'h3000, 16'hFFFF, 32'h0000_B000, 8'h02, 32'h0000_B000, 16'hFFFF},
        {16'h2400, 16'h0010, 32'h0000_A000, 8'h40, 32'h0, 16'h0},
        {16'h0500, 16'h0010, 32'h0000_A000, 8'h40, 32'h0, 16'h0},
        {16'h1000, 16'h0008, 32'h0000_0000, 8'h40, 32'h0, 16'h0},
        {16'h5600, 16'h0007, 32'h0000_1003, 8'h04, 32'h0000_1000, 16'h0004},
        {16'h4600, 16'h0002, 32'h0000_2001, 8'h08, 32'h0000_2000, 16'h0002},
        {16'h5100, 16'hFFF8, 32'h0000_3003, 8'h04, 32'h0000_3003, 16'h0001},
        {16'h4700, 16'h0004, 32'h0000_4000, 8'h40, 32'h0, 16'h0},
        {16'h5400, 16'h0004, 32'h0000_4000, 8'h40, 32'h0, 16'h0},
        {16'h6000, 16'h0000, 32'h0000_0000, 8'h10, 32'h0, 16'h0},
        {16'h7000, 16'h0000, 32'h0000_0000, 8'h20, 32'h0, 16'h0},
        {16'h9000, 16'h0000, 32'h0000_5000, 8'h00, 32'h0, 16'h0},
        {16'h4500, 16'h0006, 32'h0000_4007, 8'h40, 32'h0, 16'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] strobes();
        return {kill, stop_go, nop_go, st_go, ld_go, in_go, out_go};
    endfunction

    task automatic issue(input logic [15:0] c, input logic [CW-1:0] n,
                         input logic [AW-1:0] a, input logic [31:0] d);
        cmd_word = c; req_cnt = n; data_addr = a; dep_in = d; fetch_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic finish_op(input logic [31:0] rd);
        xfer_done = 1'b1; load_data = rd;
        @(posedge clk);
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst = 1'b1; run = 1'b1; active = 1'b1; fetch_valid = 1'b0; xfer_done = 1'b0;
        cmd_word = '0; req_cnt = '0; data_addr = '0; dep_in = '0; load_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 strobes", 64'(strobes()), 64'h0);
        chk("R10 busy/cmpl/dep_we/wake", 64'({busy, cmpl, dep_we, wake_clr}), 64'h0);
        chk("R10 data outputs", 64'({xfer_addr, store_data}), 64'h0);

        // table walk: R2 R3 R4 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [119:0] v;
            logic [6:0]   es;
            logic         eng, wrd;
            v   = VEC[i];
            es  = v[54:48];
            eng = |es[3:0];
            wrd = es[2] || es[3];
            issue(v[119:104], v[103:88], v[87:56], 32'h1122_3344);
            chk("R2 R3 R5 R9 action strobes", 64'(strobes()), 64'(es));
            chk("R1 wake_clr on accept", 64'(wake_clr), 64'h1);
            if (eng) begin
                chk("R2 R4 addr", 64'(xfer_addr), 64'(v[47:16]));
                chk("R2 R4 len", 64'(xfer_len), 64'(v[15:0]));
                chk("R8 busy set", 64'(busy), 64'h1);
                if (!wrd)
                    chk("R2 last flag", 64'(xfer_last),
                        64'(v[116:104] == 13'h0100 || v[119:112] == 8'h13 ||
                            v[119:116] == 4'h1 || v[119:116] == 4'h3));
                finish_op(32'h0);
                chk("R8 busy cleared", 64'(busy), 64'h0);
                chk("R8 cmpl pulse", 64'(cmpl), 64'h1);
                chk("R8 may_branch", 64'(cmpl_may_branch), 64'(!wrd));
            end else begin
                chk("R9 not busy", 64'(busy), 64'h0);
            end
            @(negedge clk);
            chk("R1 strobe one cycle", 64'(strobes()), 64'h0);
        end

        // R2 ctl_bits hold bit 11 and low byte
        issue(16'h6AB5, '0, '0, '0);
        chk("R2 ctl_bits", 64'(ctl_bits), 64'h1B5);

        // R7 store extraction by size, including size-code priority
        issue(16'h4600, 16'h0001, 32'h100, 32'hA1B2_C3D4);
        chk("R7 store 1 byte", 64'(store_data), 64'h0000_00A1);
        finish_op('0);
        issue(16'h4600, 16'h0003, 32'h101, 32'hA1B2_C3D4);
        chk("R7 store 2 bytes", 64'(store_data), 64'h0000_A1B2);
        chk("R4 cnt 3 gives 2", 64'({xfer_len, xfer_addr}), {16'h2, 32'h100});
        finish_op('0);
        issue(16'h4600, 16'h0006, 32'h103, 32'hA1B2_C3D4);
        chk("R7 store 4 bytes", 64'(store_data), 64'hA1B2_C3D4);
        chk("R4 cnt 6 gives 4", 64'({xfer_len, xfer_addr}), {16'h4, 32'h100});
        finish_op('0);

        // R6 load merges
        issue(16'h5000, 16'h0002, 32'h41, 32'h1234_5678);
        finish_op(32'h0000_ABCD);
        chk("R6 load 2 bytes", 64'({dep_we, dep_out}), {1'b1, 32'hABCD_5678});
        issue(16'h5000, 16'h0001, 32'h41, 32'h1234_5678);
        finish_op(32'h0000_00EF);
        chk("R6 load 1 byte", 64'({dep_we, dep_out}), {1'b1, 32'hEF34_5678});
        issue(16'h5600, 16'h0004, 32'h40, 32'h1234_5678);
        finish_op(32'hCAFE_F00D);
        chk("R6 load 4 bytes", 64'({dep_we, dep_out}), {1'b1, 32'hCAFE_F00D});
        @(negedge clk);
        chk("R6 dep_we one cycle", 64'(dep_we), 64'h0);

        // R1 gating by run, active and busy
        run = 1'b0;
        issue(16'h6000, '0, '0, '0);
        chk("R1 blocked by run", 64'({strobes(), wake_clr}), 64'h0);
        run = 1'b1; active = 1'b0;
        issue(16'h7000, '0, '0, '0);
        chk("R1 blocked by active", 64'({strobes(), wake_clr}), 64'h0);
        active = 1'b1;
        issue(16'h0000, 16'h10, 32'h800, '0);
        issue(16'h7000, '0, '0, '0);
        chk("R1 blocked by busy", 64'({strobes(), wake_clr, busy}), 64'h1);
        finish_op('0);
        chk("R8 data cmpl branch", 64'({cmpl, cmpl_may_branch}), 64'h3);
        issue(16'h7000, '0, '0, '0);
        chk("R2 stop after busy", 64'(stop_go), 64'h1);

        summary();
    end
endmodule